// File: doc/BRIEF.md
# Eight-Level Programmable Interrupt Controller

This block collects up to eight edge-triggered interrupt inputs, ranks them by fixed priority and signals the processor on a single interrupt-out line. When the processor acknowledges, the block returns an 8-bit vector number and moves the winning request into service. Level 0 ranks highest. A request is eligible only while it is pending, unmasked, not already in service, and of higher priority than every level currently in service.

Software talks to the block through a byte-wide interface with a command port and a data port, chosen by a select line. A command byte with bit 4 set starts a short initialization sequence on the data port. That sequence sets the vector base and optionally turns on automatic end-of-interrupt. After it, command bytes issue end-of-interrupt operations, turn special mask mode on or off, and choose what a command-port read returns. Data-port writes and reads outside the sequence reach the mask register.

Interrupt-out and the acknowledge vector are combinational from registered state. Each write, acknowledge or input edge therefore shows at the outputs on the clock edge that follows it.

Top module: `irq_ctrl8`

## Requirements
- R1: After reset the mask reads 0xFF, the request and in-service registers are clear, command-port reads return the request register, special mask mode and automatic end-of-interrupt are off, the vector base is 0x00, and `int_out` is low.
- R2: A command write with bit 4 set starts initialization. Its bit 1 = 1 means single mode and its bit 0 = 1 means a fourth word follows. The next data write sets the vector base to that byte with bits 2..0 cleared. Without single mode a third data word is consumed and discarded. A fourth word is consumed only when requested, and the following data write loads the mask.
- R3: Outside initialization a data-port write loads the mask register, and a data-port read (`bus_sel`=1) returns it.
- R4: A command write with bit 4 = 0 and bit 3 = 1 and bit 1 = 1 selects the command-port readback: bit 0 = 1 selects in-service and bit 0 = 0 selects request. With bit 1 = 0 the selection is unchanged.
- R5: A rising edge on `irq_in[i]` sets request bit i. A falling edge clears it if it has not been acknowledged.
- R6: `int_out` is high exactly when some request is pending, unmasked, not in service, and of lower index than the lowest-index in-service bit. The winner is the lowest such index.
- R7: An acknowledge while `int_out` is high returns `{base[7:3], level}` on `ack_vector`. It clears the winner's request bit and, with automatic end-of-interrupt off, sets its in-service bit.
- R8: Bit 1 of the fourth init word turns on automatic end-of-interrupt. While it is on, an acknowledge leaves the in-service register unchanged.
- R9: A command write with bits 6..3 = 0100 (non-specific end-of-interrupt) clears the lowest-index in-service bit. With nothing in service it changes nothing.
- R10: A command write with bits 6..3 = 1100 (specific end-of-interrupt) clears the in-service bit named by bits 2..0.
- R11: A command write with bit 4 = 0, bit 3 = 1 and bit 6 = 1 sets special mask mode to bit 5. While that mode is on, the in-service priority cutoff of R6 no longer applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_wr | input | 1 | Write strobe, one cycle per byte |
| bus_sel | input | 1 | Port select: 0 command port, 1 data port |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for the selected port (combinational) |
| irq_in | input | 8 | Edge-triggered interrupt inputs |
| ack | input | 1 | Interrupt acknowledge, one-cycle pulse |
| ack_vector | output | 8 | Vector number of the current winner |
| int_out | output | 1 | Interrupt request to the processor |

## Verification
Corrupt request, mask or in-service state shows up in three places on the cycle after the event: `int_out` rises or fails to rise, `ack_vector` names the wrong level, or a readback through the command or data port differs from the arithmetic model. The bench walks every non-empty request pattern and checks the acknowledged level, the cutoff that follows it, and the release after a non-specific end-of-interrupt. A wrong init-sequence state is exposed by the next data write landing in the mask, or failing to.

// File: rtl/irqc_pkg.sv
// Shared definitions for the eight-level interrupt controller.
// Assumes the register width equals the number of levels.
package irqc_pkg;
    localparam int IRQC_LEVELS = 8;

    // Position in the initialization word sequence
    typedef enum logic [1:0] {
        SEQ_IDLE,
        SEQ_BASE,
        SEQ_LINK,
        SEQ_MODE
    } seq_state_e;

    // Command byte bit positions decoded by the controller
    localparam int CB_INIT   = 4;
    localparam int CB_CTRL   = 3;
    localparam int CB_EOI    = 5;
    localparam int CB_SPEC   = 6;
    localparam int CB_SMM_EN = 6;
    localparam int CB_SMM_ON = 5;
    localparam int CB_RS_EN  = 1;
    localparam int CB_RS_ISR = 0;
    localparam int IW_SINGLE = 1;
    localparam int IW_NEED4  = 0;
    localparam int IW_AUTO   = 1;
endpackage

// File: rtl/irqc_req.sv
// Request register: captures rising input edges, drops a request whose
// input falls before it is acknowledged, and clears the acknowledged bit.
// Assumes inputs are already synchronous to clk.
module irqc_req #(
    parameter int N = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [N-1:0] irq_in,
    input  logic [N-1:0] ack_clr,
    output logic [N-1:0] irr
);
    logic [N-1:0] prev;
    logic [N-1:0] rise;
    logic [N-1:0] fall;

    // Edge detection against last cycle's input sample
    always_comb begin
        rise = irq_in & ~prev;
        fall = ~irq_in & prev;
    end

    // Input history and request bits
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            prev <= '0;
            irr  <= '0;
        end else begin
            prev <= irq_in;
            irr  <= (irr & ~fall & ~ack_clr) | rise;
        end
    end

    // R5: a rising input shows up as a pending request
    a_r5_rise_sets: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((irr & $past(rise)) == $past(rise)));
    // R5: a falling input leaves no pending request
    a_r5_fall_clears: assert property (@(posedge clk) disable iff (!rst_n)
        (fall != '0) |=> ((irr & $past(fall)) == '0));
endmodule

// File: rtl/irqc_prio.sv
// Fixed-priority resolver: level 0 wins. Finds the highest-priority
// in-service level and the best eligible request below that cutoff.
// Purely combinational.
module irqc_prio #(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic [N-1:0]  irr,
    input  logic [N-1:0]  imr,
    input  logic [N-1:0]  isr,
    input  logic          special,
    output logic          win_vld,
    output logic [LW-1:0] win_lvl,
    output logic          top_vld,
    output logic [LW-1:0] top_lvl
);
    logic [N-1:0] allow;
    logic [N-1:0] elig;

    // Highest-priority level currently in service
    always_comb begin
        top_vld = 1'b0;
        top_lvl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (isr[i]) begin
                top_vld = 1'b1;
                top_lvl = LW'(i);
            end
        end
    end

    // Priority cutoff and eligibility per level
    always_comb begin
        for (int i = 0; i < N; i++) begin
            allow[i] = special || !top_vld || (i < int'(top_lvl));
        end
        elig = irr & ~imr & ~isr & allow;
    end

    // Lowest-index eligible request wins
    always_comb begin
        win_vld = 1'b0;
        win_lvl = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (elig[i]) begin
                win_vld = 1'b1;
                win_lvl = LW'(i);
            end
        end
    end
endmodule

// File: rtl/irqc_cfg.sv
// Command and data port decoder: runs the initialization word sequence,
// holds mask, vector base and mode bits, and decodes end-of-interrupt
// commands into pulses for the in-service register.
// Assumes one-cycle write strobes.
module irqc_cfg
    import irqc_pkg::*;
#(
    parameter int N  = 8,
    localparam int LW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wr,
    input  logic          sel,
    input  logic [N-1:0]  wdata,
    output logic [N-1:0]  imr,
    output logic [N-1:0]  vbase,
    output logic          aeoi,
    output logic          special,
    output logic          rd_isr,
    output logic          eoi_ns,
    output logic          eoi_sp,
    output logic [LW-1:0] eoi_lvl
);
    seq_state_e seq;
    logic       single_q;
    logic       need4_q;
    logic       cmd_wr, dat_wr, is_init, is_ctrl, is_eoi;

    // Command class decode
    always_comb begin
        cmd_wr  = wr && !sel;
        dat_wr  = wr && sel;
        is_init = cmd_wr && wdata[CB_INIT];
        is_ctrl = cmd_wr && !wdata[CB_INIT] && wdata[CB_CTRL];
        is_eoi  = cmd_wr && !wdata[CB_INIT] && !wdata[CB_CTRL] && wdata[CB_EOI];
        eoi_sp  = is_eoi && wdata[CB_SPEC];
        eoi_ns  = is_eoi && !wdata[CB_SPEC];
        eoi_lvl = wdata[LW-1:0];
    end

    // Sequence state, mask, base and mode registers
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            seq      <= SEQ_IDLE;
            single_q <= 1'b0;
            need4_q  <= 1'b0;
            imr      <= '1;
            vbase    <= '0;
            aeoi     <= 1'b0;
            special  <= 1'b0;
            rd_isr   <= 1'b0;
        end else if (is_init) begin
            seq      <= SEQ_BASE;
            single_q <= wdata[IW_SINGLE];
            need4_q  <= wdata[IW_NEED4];
        end else if (is_ctrl) begin
            if (wdata[CB_RS_EN])  rd_isr  <= wdata[CB_RS_ISR];
            if (wdata[CB_SMM_EN]) special <= wdata[CB_SMM_ON];
        end else if (dat_wr) begin
            case (seq)
                SEQ_IDLE: imr <= wdata;
                SEQ_BASE: begin
                    vbase <= {wdata[N-1:LW], {LW{1'b0}}};
                    if (!single_q)    seq <= SEQ_LINK;
                    else if (need4_q) seq <= SEQ_MODE;
                    else              seq <= SEQ_IDLE;
                end
                SEQ_LINK: seq <= need4_q ? SEQ_MODE : SEQ_IDLE;
                SEQ_MODE: begin
                    aeoi <= wdata[IW_AUTO];
                    seq  <= SEQ_IDLE;
                end
                default:  seq <= SEQ_IDLE;
            endcase
        end
    end

    // R1: configuration comes out of reset masked and in default modes
    a_r1_reset_cfg: assert property (@(posedge clk) disable iff (!rst_n)
        $past(!rst_n) |-> (imr == '1 && !aeoi && !special && !rd_isr && seq == SEQ_IDLE));
    // R2: an init command always restarts at the base word
    a_r2_init_restart: assert property (@(posedge clk) disable iff (!rst_n)
        is_init |=> seq == SEQ_BASE);
    // R2: single mode never visits the link word
    a_r2_single_skip: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && seq == SEQ_BASE && single_q) |=> seq != SEQ_LINK);
    // R3: an idle data write lands in the mask
    a_r3_mask_load: assert property (@(posedge clk) disable iff (!rst_n)
        (dat_wr && seq == SEQ_IDLE) |=> imr == $past(wdata));
endmodule

// File: rtl/irq_ctrl8.sv
// Eight-level interrupt controller top: request capture, priority
// resolution, in-service tracking, acknowledge vector and port readback.
// Assumes ack is a one-cycle pulse sampled with the current ack_vector.
module irq_ctrl8
    import irqc_pkg::*;
#(
    parameter int N  = IRQC_LEVELS,
    localparam int LW = $clog2(N)
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         bus_wr,
    input  logic         bus_sel,
    input  logic [N-1:0] bus_wdata,
    output logic [N-1:0] bus_rdata,
    input  logic [N-1:0] irq_in,
    input  logic         ack,
    output logic [N-1:0] ack_vector,
    output logic         int_out
);
    localparam logic [N-1:0] ONE = {{(N-1){1'b0}}, 1'b1};

    logic [N-1:0]  irr, imr, isr, vbase;
    logic [N-1:0]  ack_clr, isr_set, isr_clr;
    logic          aeoi, special, rd_isr, eoi_ns, eoi_sp;
    logic [LW-1:0] eoi_lvl;
    logic          win_vld, top_vld, take;
    logic [LW-1:0] win_lvl, top_lvl;

    irqc_cfg #(.N(N)) u_cfg (
        .clk(clk), .rst_n(rst_n), .wr(bus_wr), .sel(bus_sel), .wdata(bus_wdata),
        .imr(imr), .vbase(vbase), .aeoi(aeoi), .special(special), .rd_isr(rd_isr),
        .eoi_ns(eoi_ns), .eoi_sp(eoi_sp), .eoi_lvl(eoi_lvl)
    );

    irqc_req #(.N(N)) u_req (
        .clk(clk), .rst_n(rst_n), .irq_in(irq_in), .ack_clr(ack_clr), .irr(irr)
    );

    irqc_prio #(.N(N)) u_prio (
        .irr(irr), .imr(imr), .isr(isr), .special(special),
        .win_vld(win_vld), .win_lvl(win_lvl), .top_vld(top_vld), .top_lvl(top_lvl)
    );

    // Acknowledge and end-of-interrupt effects on request and in-service bits
    always_comb begin
        take    = ack && win_vld;
        ack_clr = take ? (ONE << win_lvl) : '0;
        isr_set = (take && !aeoi) ? (ONE << win_lvl) : '0;
        if (eoi_sp)                 isr_clr = ONE << eoi_lvl;
        else if (eoi_ns && top_vld) isr_clr = ONE << top_lvl;
        else                        isr_clr = '0;
    end

    // In-service register
    always_ff @(posedge clk) begin
        if (!rst_n) isr <= '0;
        else        isr <= (isr & ~isr_clr) | isr_set;
    end

    // Outputs: interrupt line, vector and port readback
    always_comb begin
        int_out    = win_vld;
        ack_vector = vbase | N'(win_lvl);
        bus_rdata  = bus_sel ? imr : (rd_isr ? isr : irr);
    end

    // R6: interrupt-out never fires for a masked or in-service winner
    a_r6_clean_winner: assert property (@(posedge clk) disable iff (!rst_n)
        int_out |-> (irr[win_lvl] && !imr[win_lvl] && !isr[win_lvl]));
    // R7: an acknowledge in normal mode puts the winner in service
    a_r7_ack_in_service: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !aeoi && !bus_wr) |=> isr[$past(win_lvl)]);
    // R7: the acknowledged request is no longer pending
    a_r7_ack_clears_req: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && int_out && !irq_in[win_lvl]) |=> !irr[$past(win_lvl)]);
    // R8: automatic end-of-interrupt leaves the in-service register alone
    a_r8_auto_eoi_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (ack && aeoi && !bus_wr) |=> $stable(isr));
    // R9: non-specific end-of-interrupt with nothing in service is a no-op
    a_r9_eoi_idle: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_ns && isr == '0 && !ack) |=> isr == '0);
    // R9: non-specific end-of-interrupt removes exactly one level
    a_r9_eoi_one: assert property (@(posedge clk) disable iff (!rst_n)
        (eoi_ns && isr != '0 && !ack) |=> $countones(isr) == $countones($past(isr)) - 1);
endmodule

// File: tb/irq_ctrl8_tb.sv
`timescale 1ns/100ps
module irq_ctrl8_tb;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       bus_wr = 1'b0;
    logic       bus_sel = 1'b0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic [7:0] irq_in = '0;
    logic       ack = 1'b0;
    logic [7:0] ack_vector;
    logic       int_out;

    int n_run = 0;
    int n_fail = 0;
    bit done = 0;

    irq_ctrl8 u_dut (
        .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_sel(bus_sel),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq_in(irq_in),
        .ack(ack), .ack_vector(ack_vector), .int_out(int_out)
    );

    always #2.5 clk = ~clk;

    task automatic chk(input string tag, input int act, input int exp);
        n_run++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    // All tasks start and end at a falling edge
    task automatic wr_byte(input bit sel, input logic [7:0] v);
        bus_wr = 1'b1; bus_sel = sel; bus_wdata = v;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_byte(input bit sel, output logic [7:0] v);
        bus_sel = sel;
        #0.5 v = bus_rdata;
    endtask

    task automatic set_irq(input logic [7:0] v);
        irq_in = v;
        @(negedge clk);
    endtask

    task automatic do_ack(output logic [7:0] vec, output bit pend);
        vec = ack_vector; pend = int_out;
        ack = 1'b1;
        @(negedge clk);
        ack = 1'b0;
    endtask

    function automatic int low_bit(input logic [7:0] p);
        for (int i = 7; i >= 0; i--) if (p[i]) low_bit = i;
    endfunction

    initial begin : watchdog
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_run++; n_fail++;
            $display("FAIL watchdog actual=%0h expected=%0h", 1, 0);
            $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
            $finish;
        end
    end

    initial begin : stim
        logic [7:0] v;
        logic [7:0] vec;
        bit pend;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd_byte(1'b1, v); chk("R1 mask", v, 8'hFF);
        rd_byte(1'b0, v); chk("R1 request", v, 8'h00);
        chk("R1 int_out", int_out, 0);
        wr_byte(1'b0, 8'h0B); rd_byte(1'b0, v); chk("R1 in-service", v, 8'h00);
        wr_byte(1'b0, 8'h0A);

        // R2 cascaded, no fourth word: the third word is swallowed
        wr_byte(1'b0, 8'h10); wr_byte(1'b1, 8'h27); wr_byte(1'b1, 8'hAA);
        rd_byte(1'b1, v); chk("R2 link word not mask", v, 8'hFF);
        wr_byte(1'b1, 8'h5A); rd_byte(1'b1, v); chk("R2 mask after seq", v, 8'h5A);
        // R2 single, no fourth word
        wr_byte(1'b0, 8'h12); wr_byte(1'b1, 8'h30);
        wr_byte(1'b1, 8'h3C); rd_byte(1'b1, v); chk("R2 single short", v, 8'h3C);
        // R2 single with fourth word, base 0x4D aligns to 0x48
        wr_byte(1'b0, 8'h13); wr_byte(1'b1, 8'h4D); wr_byte(1'b1, 8'h01);
        rd_byte(1'b1, v); chk("R2 mode word not mask", v, 8'h3C);

        // R3 mask sweep
        for (int m = 0; m < 256; m++) begin
            wr_byte(1'b1, 8'(m)); rd_byte(1'b1, v); chk("R3 mask", v, m);
        end
        wr_byte(1'b1, 8'h00);

        // R5 R7 R9 single-level sweep
        for (int l = 0; l < 8; l++) begin
            set_irq(8'(1 << l));
            chk("R5 rise int_out", int_out, 1);
            rd_byte(1'b0, v); chk("R5 request bit", v, 1 << l);
            do_ack(vec, pend);
            chk("R7 vector", vec, 8'h48 + l);
            rd_byte(1'b0, v); chk("R7 request cleared", v, 0);
            wr_byte(1'b0, 8'h0B); rd_byte(1'b0, v); chk("R7 in-service set", v, 1 << l);
            chk("R7 int_out low", int_out, 0);
            set_irq(8'h00);
            wr_byte(1'b0, 8'h20); rd_byte(1'b0, v); chk("R9 eoi clears", v, 0);
            wr_byte(1'b0, 8'h0A);
        end

        // R5 fall before service
        set_irq(8'h08); set_irq(8'h00);
        rd_byte(1'b0, v); chk("R5 fall clears", v, 0);
        chk("R5 fall int_out", int_out, 0);

        // R6 priority sweep over every request pattern
        for (int p = 1; p < 256; p++) begin
            set_irq(8'(p));
            chk("R6 int_out", int_out, 1);
            do_ack(vec, pend);
            chk("R6 winner", vec, 8'h48 + low_bit(8'(p)));
            chk("R6 cutoff", int_out, 0);
            wr_byte(1'b0, 8'h20);
            chk("R9 release", int_out, ((p & (p - 1)) != 0) ? 1 : 0);
            set_irq(8'h00);
            rd_byte(1'b0, v); chk("R6 drained", v, 0);
        end

        // R6 mask gating
        wr_byte(1'b1, 8'h01); set_irq(8'h01);
        chk("R6 masked", int_out, 0);
        wr_byte(1'b1, 8'h00); chk("R6 unmasked", int_out, 1);
        set_irq(8'h00);

        // R9 R10 nesting
        set_irq(8'h20); do_ack(vec, pend);
        set_irq(8'h24); chk("R6 higher nests", int_out, 1);
        do_ack(vec, pend); chk("R7 nested vector", vec, 8'h4A);
        wr_byte(1'b0, 8'h0B); rd_byte(1'b0, v); chk("R7 nested isr", v, 8'h24);
        wr_byte(1'b0, 8'h20); rd_byte(1'b0, v); chk("R9 clears highest", v, 8'h20);
        wr_byte(1'b0, 8'h63); rd_byte(1'b0, v); chk("R10 other bit", v, 8'h20);
        wr_byte(1'b0, 8'h65); rd_byte(1'b0, v); chk("R10 named bit", v, 8'h00);
        wr_byte(1'b0, 8'h20); rd_byte(1'b0, v); chk("R9 idle ignored", v, 8'h00);
        // R4 bit 1 clear keeps selection
        wr_byte(1'b0, 8'h08); rd_byte(1'b0, v); chk("R4 keep select isr", v, 8'h00);
        set_irq(8'h00); set_irq(8'h40);
        rd_byte(1'b0, v); chk("R4 keep select isr", v, 8'h00);
        wr_byte(1'b0, 8'h0A); rd_byte(1'b0, v); chk("R4 select request", v, 8'h40);
        set_irq(8'h00);

        // R11 special mask mode
        set_irq(8'h10); do_ack(vec, pend);
        set_irq(8'h50); chk("R11 cut off", int_out, 0);
        wr_byte(1'b0, 8'h68); chk("R11 smm on", int_out, 1);
        do_ack(vec, pend); chk("R11 vector", vec, 8'h4E);
        wr_byte(1'b0, 8'h0B); rd_byte(1'b0, v); chk("R11 isr", v, 8'h50);
        wr_byte(1'b0, 8'h48);
        wr_byte(1'b0, 8'h64); wr_byte(1'b0, 8'h66);
        rd_byte(1'b0, v); chk("R10 both cleared", v, 8'h00);
        wr_byte(1'b0, 8'h0A); set_irq(8'h00);

        // R8 automatic end-of-interrupt
        wr_byte(1'b0, 8'h13); wr_byte(1'b1, 8'h4D); wr_byte(1'b1, 8'h03);
        set_irq(8'h02); do_ack(vec, pend);
        chk("R8 vector", vec, 8'h49);
        wr_byte(1'b0, 8'h0B); rd_byte(1'b0, v); chk("R8 isr empty", v, 8'h00);
        set_irq(8'h00); set_irq(8'h01);
        chk("R8 no cutoff", int_out, 1);
        set_irq(8'h00);

        done = 1;
        $display("  [TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule